// File: doc/BRIEF.md
# Single-Select SPI Word Master

This block is an SPI master with one chip-select line that a host CPU drives through five 32-bit word registers on a simple write-strobe and address bus. Reads are combinational on the address. The host first sets the word size and the clock prescale in the configuration register, then raises the chip select through the control register. Writing the transmit register then exchanges one 8-bit or 16-bit word with the slave in SPI mode 0.

When the last bit has shifted, the received word is latched into the receive register and a completion flag appears in the cause register. The host can poll that flag and clears it by writing zero. The serial clock runs at the core clock divided by an even number from 4 to 30. That divisor is chosen by a 5-bit prescale code.

Top module: `spi_word_master`

## Requirements
- R1: After reset, `spiCsN` is 1, `spiSclk` is 0, the cause register reads 0, the control register reads 0 and the configuration register reads 0x12.
- R2: Writing bit 0 of the control register (byte offset 0x00) sets the chip select: 1 drives `spiCsN` low on the next cycle and 0 drives it high. Bit 0 reads back as written, and bit 1 reads 1 exactly while a word is being exchanged.
- R3: The configuration register (offset 0x04) holds the prescale code in bits 4:0 and the word size in bit 5 (0 = 8-bit, 1 = 16-bit). All six bits read back as written.
- R4: A prescale code c from 0x12 to 0x1F gives a divisor D = 2*(c-0x10), and any code below 0x12 gives D = 4. Each serial clock period lasts D core cycles, so a word of N bits is busy for exactly N*D cycles after the edge that accepts the transmit write.
- R5: Mode 0 timing applies: the serial clock idles low, `spiMiso` is sampled at each rising serial clock edge, and `spiMosi` changes only at falling edges, so it holds steady while the clock is high. Each word produces exactly N rising edges.
- R6: A write to the transmit register (offset 0x08) while idle starts one exchange. In 8-bit mode, bits 7:0 are sent; in 16-bit mode, bits 15:0 are sent. The most significant bit goes first.
- R7: The cause register (offset 0x10) reads 1 from the cycle after the last bit completes. Writing 0 to it clears it, and writing any nonzero value leaves it unchanged.
- R8: After completion, the receive register (offset 0x0C) returns the bits sampled during that exchange, most significant first, zero-extended to 32 bits.
- R9: A write to the transmit register while an exchange is in progress is ignored. The running word, its bits and its completion time do not change.
- R10: The word size and prescale are captured when an exchange starts. Writing the configuration register mid-exchange affects only later exchanges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 5 | Byte address of the register; bits 4:2 select it |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register, combinational |
| spiSclk | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to the slave |
| spiMiso | input | 1 | Serial data from the slave |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The assertions assume that `spiMiso` only changes on falling serial clock edges. They also assume that each write strobe lasts one cycle with a stable address and data. The bench's slave model shifts its next bit only on the falling edge of `spiSclk`, and every bus write is driven at the falling core clock edge and held for one cycle. The bench performs transfers only with the chip select asserted. It places the one mid-transfer transmit write and the one mid-transfer configuration write well inside a word, so the ignore and capture properties are exercised away from the start and finish cycles.

// File: rtl/spihc_pkg.sv
package spihc_pkg;

  localparam int PRESC_W   = 5;
  localparam int HALF_W    = 4;
  localparam logic [PRESC_W-1:0] PRESC_BASE = 5'h10;
  localparam logic [PRESC_W-1:0] PRESC_MIN  = 5'h12;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_CFG   = 3'd1,
    REG_TXD   = 3'd2,
    REG_RXD   = 3'd3,
    REG_CAUSE = 3'd4
  } regIdx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new transmit word
    logic sample;  // rising serial edge: take one receive bit
    logic shift;   // falling serial edge: advance the transmit bit
    logic finish;  // last falling edge: latch the received word
    logic wide;    // word size applied on load
  } dpStrobe_t;

  // half of the serial clock period, in core cycles
  function automatic logic [HALF_W-1:0] halfFromCode(input logic [PRESC_W-1:0] code);
    if (code < PRESC_MIN) return HALF_W'(2);
    return HALF_W'(code - PRESC_BASE);
  endfunction

endpackage

// File: rtl/spihc_ctrl.sv
module spihc_ctrl
  import spihc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BUS_W     = 32,
  parameter int WORD_W    = 16,
  parameter int NARROW_W  = 8,
  parameter logic [5:0] CFG_RESET = 6'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [WORD_W-1:0] rxWord,
  output dpStrobe_t         stb,
  output logic              spiSclk,
  output logic              spiCsN
);

  localparam int BIT_CNT_W = $clog2(WORD_W);
  localparam logic [BIT_CNT_W-1:0] LAST_WIDE   = BIT_CNT_W'(WORD_W - 1);
  localparam logic [BIT_CNT_W-1:0] LAST_NARROW = BIT_CNT_W'(NARROW_W - 1);

  regIdx_e regIdx;
  logic wrCtrl, wrCfg, wrTx, wrCause;
  logic ctrlCs, causeFlag, busy, phaseHigh, wideLat;
  logic [5:0] cfgReg;
  logic [HALF_W-1:0] halfCnt, halfLat;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic lastHalf, lastBit;
  logic unusedAddrLow;

  assign unusedAddrLow = ^busAddr[1:0];
  assign regIdx  = regIdx_e'(busAddr[ADDR_W-1:2]);
  assign wrCtrl  = busWr && (regIdx == REG_CTRL);
  assign wrCfg   = busWr && (regIdx == REG_CFG);
  assign wrTx    = busWr && (regIdx == REG_TXD);
  assign wrCause = busWr && (regIdx == REG_CAUSE);

  assign lastHalf = (halfCnt == (halfLat - HALF_W'(1)));
  assign lastBit  = (bitCnt == (wideLat ? LAST_WIDE : LAST_NARROW));

  always_comb begin
    stb.load   = wrTx && !busy;
    stb.sample = busy && lastHalf && !phaseHigh;
    stb.shift  = busy && lastHalf && phaseHigh && !lastBit;
    stb.finish = busy && lastHalf && phaseHigh && lastBit;
    stb.wide   = cfgReg[5];
  end

  // host registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlCs    <= 1'b0;
      cfgReg    <= CFG_RESET;
      causeFlag <= 1'b0;
    end else begin
      if (wrCtrl) ctrlCs <= busWdata[0];
      if (wrCfg)  cfgReg <= busWdata[5:0];
      if (stb.finish)
        causeFlag <= 1'b1;
      else if (wrCause && (busWdata == '0))
        causeFlag <= 1'b0;
    end
  end

  // serial clock sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      phaseHigh <= 1'b0;
      halfCnt   <= '0;
      halfLat   <= HALF_W'(2);
      bitCnt    <= '0;
      wideLat   <= 1'b0;
    end else if (stb.load) begin
      busy      <= 1'b1;
      phaseHigh <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      halfLat   <= halfFromCode(cfgReg[PRESC_W-1:0]);
      wideLat   <= cfgReg[5];
    end else if (busy) begin
      if (lastHalf) begin
        halfCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          if (lastBit) busy <= 1'b0;
          else         bitCnt <= bitCnt + BIT_CNT_W'(1);
        end
      end else begin
        halfCnt <= halfCnt + HALF_W'(1);
      end
    end
  end

  assign spiSclk = phaseHigh;
  assign spiCsN  = !ctrlCs;

  always_comb begin
    busRdata = '0;
    case (regIdx)
      REG_CTRL:  busRdata = {{(BUS_W-2){1'b0}}, busy, ctrlCs};
      REG_CFG:   busRdata = {{(BUS_W-6){1'b0}}, cfgReg};
      REG_RXD:   busRdata = {{(BUS_W-WORD_W){1'b0}}, rxWord};
      REG_CAUSE: busRdata = {{(BUS_W-1){1'b0}}, causeFlag};
      default:   busRdata = '0;
    endcase
  end

  // R2: chip select follows the last control write
  assert_cs_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (spiCsN == !$past(busWdata[0])));

  // R5: serial clock is low whenever no word is in flight
  assert_idle_clock_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiSclk);

  // R4: captured half period stays in the legal 2..15 range
  assert_half_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfLat >= HALF_W'(2)) && (halfLat <= HALF_W'(15)));

  // R9: a transmit write during a word neither restarts nor ends it
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrTx && !stb.finish) |=> (busy && $stable(halfLat) && $stable(wideLat)));

  // R7: completion raises the cause flag
  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> causeFlag);

  // R7: a zero write clears the flag when no word completes
  assert_cause_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCause && (busWdata == '0) && !stb.finish) |=> !causeFlag);

endmodule

// File: rtl/spihc_datapath.sv
module spihc_datapath
  import spihc_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic [WORD_W-1:0] rxWord
);

  localparam logic [WORD_W-1:0] NARROW_MASK = WORD_W'((1 << NARROW_W) - 1);

  logic [WORD_W-1:0] txSh, rxSh, rxHold;
  logic wideDp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rxHold <= '0;
      wideDp <= 1'b0;
    end else begin
      if (stb.load) begin
        txSh   <= txWord;
        rxSh   <= '0;
        wideDp <= stb.wide;
      end else begin
        if (stb.shift)  txSh <= txSh << 1;
        if (stb.sample) rxSh <= {rxSh[WORD_W-2:0], spiMiso};
      end
      if (stb.finish)
        rxHold <= wideDp ? rxSh : (rxSh & NARROW_MASK);
    end
  end

  assign spiMosi = wideDp ? txSh[WORD_W-1] : txSh[NARROW_W-1];
  assign rxWord  = rxHold;

  // R8: a narrow word leaves the upper receive bits zero
  assert_rx_zero_ext_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !wideDp) |=> (rxHold[WORD_W-1:NARROW_W] == '0));

  // R6: load and shift never coincide
  assert_load_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !stb.shift && !stb.sample && !stb.finish);

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spihc_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int BUS_W    = 32,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiCsN
);

  dpStrobe_t stb;
  logic [WORD_W-1:0] rxWord;

  spihc_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxWord(rxWord),
    .stb(stb), .spiSclk(spiSclk), .spiCsN(spiCsN)
  );

  spihc_datapath #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(busWdata[WORD_W-1:0]),
    .spiMiso(spiMiso), .spiMosi(spiMosi), .rxWord(rxWord)
  );

  // R5: data out holds while the serial clock is high
  assert_mosi_stable_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));

endmodule

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;

  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TXD = 5'h08,
                         A_RXD = 5'h0C, A_CAUSE = 5'h10;

  typedef struct packed {
    logic [4:0]  code;
    logic        wide;
    logic [15:0] tx;
    logic [15:0] slave;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{5'h12, 1'b0, 16'h00A5, 16'h003C},
    '{5'h1F, 1'b1, 16'hBEEF, 16'h1234},
    '{5'h15, 1'b0, 16'h0080, 16'h0001},
    '{5'h18, 1'b1, 16'h8001, 16'hFFFF},
    '{5'h03, 1'b0, 16'h005A, 16'h00C3},
    '{5'h1A, 1'b1, 16'h0F0F, 16'h0000}
  };

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic spiSclk, spiMosi, spiMiso, spiCsN;

  int tests = 0, fails = 0;
  bit finished = 0;

  // slave model: next bit on falling edge, capture on rising edge
  logic [15:0] slaveSh = '0;
  logic slaveWide = 1'b0;
  logic [15:0] mosiCap = '0;
  int riseCnt = 0;

  always #5 clk = ~clk;

  spi_word_master dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  assign spiMiso = slaveWide ? slaveSh[15] : slaveSh[7];
  always @(negedge spiSclk) slaveSh <= slaveSh << 1;
  always @(posedge spiSclk) begin
    mosiCap <= {mosiCap[14:0], spiMosi};
    riseCnt <= riseCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic int divOf(input logic [4:0] code);
    return (code < 5'h12) ? 4 : 2 * (int'(code) - 16);
  endfunction

  // prepare slave, start a word; returns at the falling edge after acceptance
  task automatic startWord(input logic [4:0] code, input logic wide,
                           input logic [15:0] tx, input logic [15:0] slave);
    busWrite(A_CFG, {26'd0, wide, code});
    busWrite(A_CAUSE, 32'd0);
    busWrite(A_CTRL, 32'd1);
    slaveSh = slave; slaveWide = wide; mosiCap = '0; riseCnt = 0;
    busWrite(A_TXD, {16'd0, tx});
  endtask

  task automatic finishWord(input string tag, input int cycles, input logic wide,
                            input logic [15:0] tx, input logic [15:0] slave);
    logic [31:0] r;
    int n;
    n = wide ? 16 : 8;
    repeat (cycles - 1) @(posedge clk);
    @(negedge clk);
    busRead(A_CTRL, r);  chk({tag, " R4 busy before end"}, {31'd0, r[1]}, 32'd1);
    busRead(A_CAUSE, r); chk({tag, " R7 cause before end"}, r, 32'd0);
    @(posedge clk); @(negedge clk);
    busRead(A_CTRL, r);  chk({tag, " R4 idle at end"}, {31'd0, r[1]}, 32'd0);
    busRead(A_CAUSE, r); chk({tag, " R7 cause set"}, r, 32'd1);
    chk({tag, " R5 rising edges"}, riseCnt, n);
    chk({tag, " R6 mosi bits"}, wide ? {16'd0, mosiCap} : {24'd0, mosiCap[7:0]},
        wide ? {16'd0, tx} : {24'd0, tx[7:0]});
    busRead(A_RXD, r);
    chk({tag, " R8 rx word"}, r, wide ? {16'd0, slave} : {24'd0, slave[7:0]});
    chk({tag, " R5 sclk idle"}, {31'd0, spiSclk}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 csN", {31'd0, spiCsN}, 32'd1);
    chk("R1 sclk", {31'd0, spiSclk}, 32'd0);
    busRead(A_CAUSE, r); chk("R1 cause", r, 32'd0);
    busRead(A_CTRL, r);  chk("R1 ctrl", r, 32'd0);
    busRead(A_CFG, r);   chk("R1 cfg", r, 32'h12);

    // R2 chip select
    busWrite(A_CTRL, 32'd1);
    chk("R2 csN low", {31'd0, spiCsN}, 32'd1 ^ 32'd1);
    busRead(A_CTRL, r); chk("R2 readback", r, 32'd1);
    busWrite(A_CTRL, 32'd0);
    chk("R2 csN high", {31'd0, spiCsN}, 32'd1);

    // R3 configuration readback
    busWrite(A_CFG, 32'h0000_0FFF);
    busRead(A_CFG, r); chk("R3 cfg bits", r, 32'h3F);

    // table of transfers
    for (int i = 0; i < NVEC; i++) begin
      startWord(VECS[i].code, VECS[i].wide, VECS[i].tx, VECS[i].slave);
      finishWord($sformatf("vec%0d", i),
                 (VECS[i].wide ? 16 : 8) * divOf(VECS[i].code),
                 VECS[i].wide, VECS[i].tx, VECS[i].slave);
    end

    // R7 nonzero write keeps the flag, zero clears it
    busWrite(A_CAUSE, 32'd5);
    busRead(A_CAUSE, r); chk("R7 nonzero write kept", r, 32'd1);
    busWrite(A_CAUSE, 32'd0);
    busRead(A_CAUSE, r); chk("R7 zero write cleared", r, 32'd0);

    // R9 transmit write mid-word is ignored
    startWord(5'h12, 1'b0, 16'h0096, 16'h0071);
    repeat (4) @(negedge clk);
    busWrite(A_TXD, 32'h0000_0000);
    finishWord("R9 ignore", 32 - 6, 1'b0, 16'h0096, 16'h0071);

    // R10 configuration change mid-word does not affect it
    startWord(5'h12, 1'b0, 16'h00C9, 16'h00E4);
    repeat (3) @(negedge clk);
    busWrite(A_CFG, 32'h3F);
    finishWord("R10 latched cfg", 32 - 5, 1'b0, 16'h00C9, 16'h00E4);
    busRead(A_CFG, r); chk("R10 new cfg stored", r, 32'h3F);

    busWrite(A_CTRL, 32'd0);
    chk("R2 csN released", {31'd0, spiCsN}, 32'd1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule